// File: doc/BRIEF.md
# Serial PCM Output Formatter

This block takes decoded stereo sample pairs and shifts them out on a three-wire serial audio link. The link has a data line (`sdo`), a bit clock (`sckt`) and a frame clock (`lrckt`) that tells which channel is being sent. Each frame carries a left slot followed by a right slot. A slot is either 16 or 32 bit clocks long.

The word sent in each slot is the top 16, 18, 20 or 24 bits of a 24-bit input sample. It can go out most significant bit first or least significant bit first. In 32-clock slots the word can sit at the start or at the end of the slot, and every other bit of the slot is zero.

Once per frame the block pulses `smp_req`. The source answers with `smp_valid` and the next pair. A decoder-state input and the play and mute controls decide whether the clocks run and whether real data or zeros are sent. The bit clock is derived from the system clock by a fixed divider.

Top module: `pcm_serializer`

## Requirements
- R1: `prec_sel` picks the word precision: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. The word is the top bits of the 24-bit input sample, so bit 23 is the word's most significant bit.
- R2: With `lsb_first`=0 the word is sent most significant bit first. With `lsb_first`=1 it is sent least significant bit first.
- R3: With `slot32`=0 each slot is 16 bit clocks long; with `slot32`=1 it is 32. A frame is the left slot followed by the right slot.
- R4: `lrckt` is 0 for the left channel and 1 for the right channel. It switches one bit clock early: while bit p of a frame is on `sdo`, `lrckt` shows the channel of bit p+1.
- R5: In 32-clock slots, `right_just`=0 puts the word at the start of the slot and `right_just`=1 puts it at the end of the slot. All other bits of the slot are 0.
- R6: In 16-clock slots, a precision above 16 is cut to the 16 most significant bits.
- R7: `sdo` and `lrckt` change only on a falling edge of `sckt`, or when the clocks stop.
- R8: In decode state (`dec_state`=2), the gating is as follows:
  - play=1, mute=0: decoded data is sent.
  - play=1, mute=1: the clocks run and the data is zero.
  - play=0, mute=1: the clocks run and the data is zero.
  - play=0, mute=0: `sckt` stays low and `sdo` stays 0.
- R9: In idle (`dec_state`=0) or init (`dec_state`=1), mute=1 runs the clocks with zero data, and mute=0 stops them with `sdo` at 0.
- R10: While in init, changes on `play` and `mute` have no effect. The values held on entry to init stay in force until the state changes.
- R11: `smp_req` is a one-cycle pulse at the first bit of each frame. A pair accepted with `smp_valid` is sent in the next frame.
- R12: If no pair was accepted since the last frame start, the frame carries zeros.
- R13: After reset, `sckt`, `sdo`, `lrckt` and `smp_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| left_in | input | SAMPLE_W | Left sample, MSB-aligned |
| right_in | input | SAMPLE_W | Right sample, MSB-aligned |
| smp_valid | input | 1 | Pair on the sample inputs is valid this cycle |
| smp_req | output | 1 | One-cycle request for the next pair |
| prec_sel | input | 2 | Word precision code |
| lsb_first | input | 1 | Bit order select |
| slot32 | input | 1 | Slot length: 0 gives 16 clocks, 1 gives 32 clocks |
| right_just | input | 1 | Word placement inside a 32-clock slot |
| play | input | 1 | Play control |
| mute | input | 1 | Mute control |
| dec_state | input | 2 | Decoder state: 0 idle, 1 init, 2 decode |
| sdo | output | 1 | Serial data |
| sckt | output | 1 | Bit clock |
| lrckt | output | 1 | Channel clock |

## Verification
The assertions assume that `smp_valid` is a single-cycle answer to a request. They also assume the configuration inputs hold still while the clocks run. The bench stops the clocks through the play and mute controls before it changes precision, order, slot length or justification. It answers each `smp_req` once, on the falling clock edge that follows it. Changes to the decoder state and the play and mute controls land between system clock edges; they are the only inputs that move while the clocks run.

// File: rtl/pcm_serializer.sv
module pcm_serializer #(
  parameter int SAMPLE_W = 24,
  parameter int HALF_DIV = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  input  logic                smp_valid,
  output logic                smp_req,
  input  logic [1:0]          prec_sel,
  input  logic                lsb_first,
  input  logic                slot32,
  input  logic                right_just,
  input  logic                play,
  input  logic                mute,
  input  logic [1:0]          dec_state,
  output logic                sdo,
  output logic                sckt,
  output logic                lrckt
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [1:0] ST_INIT = 2'd1;
  localparam logic [1:0] ST_DEC  = 2'd2;

  logic [1:0]          st_q;
  logic                hold_play, hold_mute;
  logic [DIV_W-1:0]    divcnt;
  logic [5:0]          bitpos;
  logic [SAMPLE_W-1:0] cur_l, cur_r, pend_l, pend_r;
  logic                pend_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q      <= 2'd0;
      hold_play <= 1'b0;
      hold_mute <= 1'b0;
    end else begin
      st_q <= dec_state;
      if (dec_state != ST_INIT) begin
        hold_play <= play;
        hold_mute <= mute;
      end
    end

  logic clk_run, data_on;
  assign clk_run = (st_q == ST_DEC) ? (hold_play | hold_mute) : hold_mute;
  assign data_on = (st_q == ST_DEC) & hold_play & ~hold_mute;

  logic tog, fall_ev, frame_start, bit_n, lr_n;
  logic [5:0] npos;
  logic [SAMPLE_W-1:0] nl, nr;

  assign tog     = clk_run && (divcnt == DIV_W'(HALF_DIV - 1));
  assign fall_ev = tog && sckt;

  always_comb begin
    int s_len, f_len, w_len, off, k, j, idx, bp, np, p1;
    logic ch;
    s_len = slot32 ? 32 : 16;
    f_len = 2 * s_len;
    case (prec_sel)
      2'd0:    w_len = 16;
      2'd1:    w_len = 18;
      2'd2:    w_len = 20;
      default: w_len = 24;
    endcase
    if (w_len > s_len) w_len = s_len;
    bp = int'(bitpos);
    np = (bp >= f_len - 1) ? 0 : bp + 1;
    p1 = (np >= f_len - 1) ? 0 : np + 1;
    frame_start = fall_ev && (np == 0);
    nl = frame_start ? (pend_v ? pend_l : '0) : cur_l;
    nr = frame_start ? (pend_v ? pend_r : '0) : cur_r;
    ch = (np >= s_len);
    k = ch ? np - s_len : np;
    off = (slot32 && right_just) ? s_len - w_len : 0;
    j = k - off;
    idx = lsb_first ? (SAMPLE_W - w_len + j) : (SAMPLE_W - 1 - j);
    if (idx < 0) idx = 0;
    if (idx > SAMPLE_W - 1) idx = SAMPLE_W - 1;
    bit_n = data_on && (k >= off) && (k < off + w_len) && (ch ? nr[idx] : nl[idx]);
    lr_n = (p1 >= s_len);
    npos = 6'(np);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      divcnt  <= '0;
      sckt    <= 1'b0;
      sdo     <= 1'b0;
      lrckt   <= 1'b0;
      bitpos  <= 6'd63;
      smp_req <= 1'b0;
      cur_l   <= '0;
      cur_r   <= '0;
    end else if (!clk_run) begin
      divcnt  <= '0;
      sckt    <= 1'b0;
      sdo     <= 1'b0;
      lrckt   <= 1'b0;
      bitpos  <= 6'd63;
      smp_req <= 1'b0;
    end else begin
      divcnt  <= tog ? '0 : divcnt + 1'b1;
      smp_req <= frame_start;
      if (tog) sckt <= ~sckt;
      if (fall_ev) begin
        bitpos <= npos;
        sdo    <= bit_n;
        lrckt  <= lr_n;
      end
      if (frame_start) begin
        cur_l <= nl;
        cur_r <= nr;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_l <= '0;
      pend_r <= '0;
    end else if (smp_valid) begin
      pend_v <= 1'b1;
      pend_l <= left_in;
      pend_r <= right_in;
    end else if (frame_start) begin
      pend_v <= 1'b0;
    end

  // R7
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> ($fell(sckt) || !$past(clk_run)));

  // R7
  lr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrckt) |-> ($fell(sckt) || !$past(clk_run)));

  // R11
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req |=> !smp_req);

  // R8
  stop_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_run |=> (!sckt && !sdo));

  // R11
  req_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_req) |-> $fell(sckt));

endmodule

// File: tb/pcm_serializer_bench.sv
module pcm_serializer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [23:0] left_in = '0, right_in = '0;
  logic smp_valid = 1'b0, smp_req;
  logic [1:0] prec_sel = 2'd0;
  logic lsb_first = 1'b0, slot32 = 1'b0, right_just = 1'b0;
  logic play = 1'b0, mute = 1'b0;
  logic [1:0] dec_state = 2'd0;
  logic sdo, sckt, lrckt;

  always #2 clk = ~clk;

  pcm_serializer u_pcm_serializer (
    .clk(clk), .rst_n(rst_n), .left_in(left_in), .right_in(right_in),
    .smp_valid(smp_valid), .smp_req(smp_req), .prec_sel(prec_sel),
    .lsb_first(lsb_first), .slot32(slot32), .right_just(right_just),
    .play(play), .mute(mute), .dec_state(dec_state),
    .sdo(sdo), .sckt(sckt), .lrckt(lrckt));

  int errors = 0, checks = 0;
  logic resp_en = 1'b0, capturing = 1'b0, prev_sck = 1'b0;
  int rises = 0, nreq = 0;
  logic cap_sdo [0:255];
  logic cap_lr  [0:255];

  initial forever begin
    @(negedge clk);
    smp_valid = smp_req && resp_en;
  end

  initial forever begin
    @(negedge clk);
    if (capturing) begin
      if (sckt && !prev_sck) begin
        if (rises > 0 && rises <= 256) begin
          cap_sdo[rises-1] = sdo;
          cap_lr[rises-1]  = lrckt;
        end
        rises++;
      end
      if (smp_req) nreq++;
    end
    prev_sck = sckt;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(int p, int pr, bit lsb, bit s32, bit rj,
                                   logic [23:0] l, logic [23:0] r);
    int s = s32 ? 32 : 16;
    int wl = (pr == 0) ? 16 : (pr == 1) ? 18 : (pr == 2) ? 20 : 24;
    int k = p % s;
    int off;
    logic [23:0] w = (p >= s) ? r : l;
    if (wl > s) wl = s;
    off = (s32 && rj) ? s - wl : 0;
    if (k < off || k >= off + wl) return 1'b0;
    return lsb ? w[24 - wl + (k - off)] : w[23 - (k - off)];
  endfunction

  task automatic stop_clocks();
    dec_state = 2'd2; play = 1'b0; mute = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic frame_case(string req, int pr, bit lsb, bit s32, bit rj,
                            logic [23:0] l, logic [23:0] r, bit pl, bit mu,
                            bit resp, bit data_exp);
    int s = s32 ? 32 : 16;
    int f = 2 * s;
    int guard = 0;
    logic [63:0] a_d = '0, e_d = '0, a_l = '0, e_l = '0;
    stop_clocks();
    prec_sel = 2'(pr); lsb_first = lsb; slot32 = s32; right_just = rj;
    left_in = l; right_in = r; resp_en = resp;
    rises = 0; nreq = 0; capturing = 1'b1;
    play = pl; mute = mu;
    while (rises < 2 * f + 1 && guard < 5000) begin
      @(negedge clk); guard++;
    end
    capturing = 1'b0;
    for (int p = 0; p < f; p++) begin
      a_d[p] = cap_sdo[f + p];
      a_l[p] = cap_lr[f + p];
      e_d[p] = data_exp ? exp_bit(p, pr, lsb, s32, rj, l, r) : 1'b0;
      e_l[p] = ((p + 1) % f) >= s;
    end
    check({req, " data"}, a_d, e_d);
    check("R4 lrckt", a_l, e_l);
  endtask

  task automatic run_check(string req, bit exp_run);
    int n = 0;
    logic ds = 1'b0, pv = sckt;
    repeat (100) begin
      @(negedge clk);
      if (sckt && !pv) n++;
      if (sdo) ds = 1'b1;
      pv = sckt;
    end
    check({req, " clock running"}, 64'(n > 0), 64'(exp_run));
    check({req, " data zero"}, 64'(ds), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13", {60'd0, sckt, sdo, lrckt, smp_req}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    frame_case("R1 R2 R3 16b msb slot16", 0, 0, 0, 0, 24'hA5C3F0, 24'h3C5A0F, 1, 0, 1, 1);
    frame_case("R1 R3 24b msb slot32", 3, 0, 1, 0, 24'h9ABCDE, 24'h123457, 1, 0, 1, 1);
    frame_case("R2 R5 18b lsb right", 1, 1, 1, 1, 24'hF0E1D2, 24'h8C7B6A, 1, 0, 1, 1);
    frame_case("R5 R1 20b msb right", 2, 0, 1, 1, 24'hB1C2D3, 24'h4E5F61, 1, 0, 1, 1);
    frame_case("R6 24b in slot16", 3, 0, 0, 0, 24'hDEADBE, 24'h7F00FF, 1, 0, 1, 1);
    frame_case("R2 R6 20b lsb slot16", 2, 1, 0, 0, 24'h13579B, 24'hECA864, 1, 0, 1, 1);
    check("R11 one request per frame", 64'(nreq), 64'd2);
    frame_case("R12 no sample", 3, 0, 1, 0, 24'hFFFFFF, 24'hFFFFFF, 1, 0, 0, 0);
    frame_case("R8 play mute", 0, 0, 0, 0, 24'hFFFFFF, 24'hFFFFFF, 1, 1, 1, 0);
    frame_case("R8 mute only", 0, 0, 0, 0, 24'hFFFFFF, 24'hFFFFFF, 0, 1, 1, 0);

    stop_clocks();
    run_check("R8 stopped", 1'b0);

    dec_state = 2'd0; play = 1'b1; mute = 1'b1;
    run_check("R9 idle mute", 1'b1);
    mute = 1'b0;
    run_check("R9 idle no mute", 1'b0);

    mute = 1'b1;
    repeat (4) @(negedge clk);
    dec_state = 2'd1;
    repeat (4) @(negedge clk);
    mute = 1'b0; play = 1'b1;
    run_check("R10 init holds mute", 1'b1);

    dec_state = 2'd2; play = 1'b0; mute = 1'b0;
    run_check("R8 leave init", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule